// File: doc/BRIEF.md
# Page Write Sequencer with Deferred Commit

This block sits behind the write side of a serial memory slave. The slave engine opens a write command with a bank index and a start byte address, then presents each received data byte with a one-cycle strobe. The block gathers those bytes into an eight-lane page buffer. The lane pointer advances only within the page, so the upper address bits stay where the command put them.

Nothing reaches the storage array until the command closes with a STOP while the write-protect level is high and the supply is healthy. An accepted STOP starts a write window that lasts a programmable number of clocks. During that window the block reports busy and ignores every input from the slave engine. When the window ends, the received lanes are written to the array in one cycle. If the protect level drops during the window, the write is cut short and the received locations are filled with a marker value, which models a corrupted cell.

The array holds one page-addressable storage region per bank. It can be read through a combinational port, so the surrounding read logic, or a bench, can inspect it.

Top module: `pwseq_page_writer`

## Requirements
- R1: After reset every location of every bank reads 0xFF and busy_o is low.
- R2: An accepted STOP raises busy_o on the next clock edge. busy_o then stays high for exactly TWR_CYCLES cycles. The received bytes appear in the array on the edge where busy_o falls, and not before.
- R3: Each byte goes to the lane given by the low three address bits, starting at the open address, and that lane index then wraps modulo 8. Address bits above bit 2 never change. When more than 8 bytes arrive, the later byte in a lane replaces the earlier one.
- R4: Lanes of the page that received no byte keep their previous contents after a commit.
- R5: A command that ends with cmd_drop_i instead of stop_i stores nothing and leaves busy_o low.
- R6: While busy_o is high, cmd_open_i, byte_vld_i and stop_i have no effect. No data is stored from them and no second write window follows.
- R7: If wp_hi_i is low in any cycle from the open up to the STOP, that STOP stores nothing and busy_o stays low.
- R8: If wp_hi_i goes low while busy_o is high, busy_o falls on the next edge. Every location that received a byte then reads MARKER (default 0xA5), and the other locations of the page are unchanged.
- R9: A STOP presented while low_vdd_i is high stores nothing and busy_o stays low.
- R10: A STOP after an open with no data bytes leaves busy_o low and changes nothing.
- R11: Banks are independent. Bank index 0 to BANKS-1 selects a bank. A write to one bank leaves the same address in the other banks untouched, and an open with a bank index of BANKS or more is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_open_i | input | 1 | Pulse that opens a write command |
| bank_i | input | BANK_W | Bank index, sampled with cmd_open_i |
| addr_i | input | AW | Start byte address, sampled with cmd_open_i |
| byte_vld_i | input | 1 | Strobe for one data byte |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Command closed by STOP: request a commit |
| cmd_drop_i | input | 1 | Command closed without STOP: discard |
| wp_hi_i | input | 1 | Write-protect level, high permits writing |
| low_vdd_i | input | 1 | Supply below the write threshold |
| busy_o | output | 1 | Write window in progress |
| rd_bank_i | input | BANK_W | Read port bank index |
| rd_addr_i | input | AW | Read port byte address |
| rd_data_o | output | 8 | Read port data, combinational |

## Verification
The bench builds the block with TWR_CYCLES set to 20, and keeps three banks of 256 bytes and the 0xA5 marker. The short window lets the bench count the busy interval edge by edge. It also lets the bench inject a full command in the middle of that interval and drop the protect level part way through it, all within a few hundred cycles. Full-size banks allow a page at the very top of the address range and wraps that cross a page's lane 7.

// File: rtl/pwseq_pkg.sv
package pwseq_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = $clog2(LANES);

  typedef logic [7:0]             byte_t;
  typedef logic [LANES-1:0][7:0]  page_data_t;
  typedef logic [LANES-1:0]       lane_mask_t;
endpackage

// File: rtl/pwseq_page_buf.sv
module pwseq_page_buf
  import pwseq_pkg::*;
#(
  parameter int AW     = 8,
  localparam int PAGE_W = AW - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              push_i,
  input  byte_t             byte_i,
  output logic [PAGE_W-1:0] page_o,
  output page_data_t        data_o,
  output lane_mask_t        mask_o
);
  logic [LANE_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= '0;
      ptr_q  <= '0;
      mask_o <= '0;
      data_o <= '0;
    end else if (load_i) begin
      page_o <= addr_i[AW-1:LANE_W];
      ptr_q  <= addr_i[LANE_W-1:0];
      mask_o <= '0;
    end else if (push_i) begin
      data_o[ptr_q] <= byte_i;
      mask_o[ptr_q] <= 1'b1;
      ptr_q         <= ptr_q + LANE_W'(1);  // wraps inside the page
    end
  end

  a_r3_page_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(page_o));
  a_r3_push_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !load_i |=> mask_o != '0);
endmodule

// File: rtl/pwseq_timer.sv
module pwseq_timer #(
  parameter int TWR_CYCLES = 250000,
  localparam int CNT_W = $clog2(TWR_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  output logic busy_o,
  output logic done_o,
  output logic abort_o
);
  logic [CNT_W-1:0] cnt_q;

  assign busy_o  = cnt_q != '0;
  assign abort_o = busy_o && !hold_i;
  assign done_o  = busy_o && hold_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= CNT_W'(TWR_CYCLES);
    else if (abort_o)     cnt_q <= '0;
    else if (busy_o)      cnt_q <= cnt_q - CNT_W'(1);
  end

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r6_start_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  a_r8_abort_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !busy_o);
  a_r2_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/pwseq_array.sv
module pwseq_array
  import pwseq_pkg::*;
#(
  parameter int          BANKS  = 3,
  parameter int          AW     = 8,
  parameter logic [7:0]  MARKER = 8'hA5,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int DEPTH  = 2 ** AW,
  localparam int PAGE_W = AW - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              abort_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [PAGE_W-1:0] page_i,
  input  page_data_t        data_i,
  input  lane_mask_t        mask_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [AW-1:0]     rd_addr_i,
  output byte_t             rd_data_o
);
  byte_t rd_vec [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    byte_t mem [DEPTH];
    logic  hit;
    assign hit = (we_i || abort_i) && (bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (hit) begin
        for (int j = 0; j < LANES; j++) begin
          if (mask_i[j])
            mem[{page_i, LANE_W'(j)}] <= abort_i ? MARKER : data_i[j];
        end
      end
    end

    assign rd_vec[b] = mem[rd_addr_i];
  end

  assign rd_data_o = (32'(rd_bank_i) < BANKS) ? rd_vec[rd_bank_i] : 8'hFF;

  a_r8_excl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && abort_i));
  a_r10_write_has_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> $countones(mask_i) > 0);
endmodule

// File: rtl/pwseq_page_writer.sv
module pwseq_page_writer
  import pwseq_pkg::*;
#(
  parameter int         BANKS      = 3,
  parameter int         AW         = 8,
  parameter int         TWR_CYCLES = 250000,
  parameter logic [7:0] MARKER     = 8'hA5,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int PAGE_W = AW - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_open_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic              cmd_drop_i,
  input  logic              wp_hi_i,
  input  logic              low_vdd_i,
  output logic              busy_o,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic              open_q, spoil_q;
  logic [BANK_W-1:0] bank_q;
  logic              open_ok, push, start;
  logic              done, abort;
  logic [PAGE_W-1:0] page;
  page_data_t        pdata;
  lane_mask_t        pmask;

  assign open_ok = cmd_open_i && !busy_o && (32'(bank_i) < BANKS);
  assign push    = byte_vld_i && open_q && !open_ok && !busy_o;
  assign start   = stop_i && open_q && !open_ok && !busy_o && !spoil_q
                   && wp_hi_i && !low_vdd_i && (pmask != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      spoil_q <= 1'b0;
      bank_q  <= '0;
    end else if (open_ok) begin
      open_q  <= 1'b1;
      spoil_q <= !wp_hi_i;
      bank_q  <= bank_i;
    end else if (open_q) begin
      if (stop_i || cmd_drop_i) open_q <= 1'b0;
      if (!wp_hi_i)             spoil_q <= 1'b1;  // sticky until next open
    end
  end

  pwseq_page_buf #(.AW(AW)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (open_ok),
    .addr_i (addr_i),
    .push_i (push),
    .byte_i (byte_i),
    .page_o (page),
    .data_o (pdata),
    .mask_o (pmask)
  );

  pwseq_timer #(.TWR_CYCLES(TWR_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .hold_i  (wp_hi_i),
    .busy_o  (busy_o),
    .done_o  (done),
    .abort_o (abort)
  );

  pwseq_array #(.BANKS(BANKS), .AW(AW), .MARKER(MARKER)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (done),
    .abort_i   (abort),
    .bank_i    (bank_q),
    .page_i    (page),
    .data_i    (pdata),
    .mask_i    (pmask),
    .rd_bank_i (rd_bank_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  a_r9_no_start_low_vdd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_vdd_i |-> !start);
  a_r7_no_start_spoiled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spoil_q && !open_ok |-> !start);
  a_r6_bank_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(bank_q));
  a_r5_drop_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_drop_i && !open_ok |=> !open_q && !busy_o);
endmodule

// File: tb/pwseq_page_writer_tb.sv
module pwseq_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TWR = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_open = 1'b0, byte_vld = 1'b0, stop = 1'b0, drop = 1'b0;
  logic       wp_hi = 1'b1, low_vdd = 1'b0;
  logic [1:0] bank = '0, rd_bank = '0;
  logic [7:0] addr = '0, byte_d = '0, rd_addr = '0, rd_data;
  logic       busy;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwseq_page_writer #(.TWR_CYCLES(TWR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_open_i(cmd_open), .bank_i(bank),
    .addr_i(addr), .byte_vld_i(byte_vld), .byte_i(byte_d), .stop_i(stop),
    .cmd_drop_i(drop), .wp_hi_i(wp_hi), .low_vdd_i(low_vdd), .busy_o(busy),
    .rd_bank_i(rd_bank), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  typedef struct packed {
    logic [1:0] bank; logic [7:0] addr; logic [4:0] n; logic [7:0] d0;
    logic stp; logic [7:0] caddr; logic [7:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h10, 5'd1,  8'h11, 1'b1, 8'h10, 8'h11, 4'd2},  // R2 single byte
    '{2'd1, 8'h2E, 5'd4,  8'h40, 1'b1, 8'h28, 8'h42, 4'd3},  // R3 wrap lane7->0
    '{2'd1, 8'h2A, 5'd0,  8'h00, 1'b1, 8'h2A, 8'hFF, 4'd4},  // R4 lane untouched
    '{2'd2, 8'h07, 5'd10, 8'h80, 1'b1, 8'h00, 8'h89, 4'd3},  // R3 later byte wins
    '{2'd0, 8'h10, 5'd1,  8'h22, 1'b0, 8'h10, 8'h11, 4'd5},  // R5 no STOP
    '{2'd2, 8'h07, 5'd0,  8'h00, 1'b0, 8'h07, 8'h88, 4'd3},  // R3 overwrite lane7
    '{2'd0, 8'hF8, 5'd8,  8'hC0, 1'b1, 8'hFF, 8'hC7, 4'd2},  // R2 top page
    '{2'd1, 8'h10, 5'd0,  8'h00, 1'b0, 8'h10, 8'hFF, 4'd11}  // R11 bank isolation
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] b, input logic [7:0] a, output logic [7:0] v);
    rd_bank = b; rd_addr = a; #1; v = rd_data;
  endtask

  task automatic run_cmd(input logic [1:0] b, input logic [7:0] a, input int n,
                         input logic [7:0] d0, input logic stp);
    @(negedge clk); cmd_open = 1'b1; bank = b; addr = a;
    @(negedge clk); cmd_open = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_vld = 1'b1; byte_d = d0 + 8'(k); @(negedge clk);
    end
    byte_vld = 1'b0;
    if (stp) stop = 1'b1; else drop = 1'b1;
    @(negedge clk); stop = 1'b0; drop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    rd(2'd0, 8'h00, v); chk("R1 bank0", v, 8'hFF);
    rd(2'd2, 8'hFF, v); chk("R1 bank2", v, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VECS[i].bank, VECS[i].addr, int'(VECS[i].n), VECS[i].d0, VECS[i].stp);
      chk($sformatf("R%0d vec%0d busy", VECS[i].req, i), busy,
          VECS[i].stp && (VECS[i].n != 0));
      wait_idle();
      rd(VECS[i].bank, VECS[i].caddr, v);
      chk($sformatf("R%0d vec%0d data", VECS[i].req, i), v, VECS[i].exp);
    end
    rd(2'd2, 8'h08, v); chk("R3 next page kept", v, 8'hFF);

    // R2 busy length and late store
    run_cmd(2'd0, 8'h40, 2, 8'h31, 1'b1);
    chk("R2 busy rises", busy, 1);
    rd(2'd0, 8'h40, v); chk("R2 not before end", v, 8'hFF);
    cnt = 0;
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R2 busy cycles", cnt, TWR);
    rd(2'd0, 8'h40, v); chk("R2 lane0", v, 8'h31);
    rd(2'd0, 8'h41, v); chk("R2 lane1", v, 8'h32);
    rd(2'd0, 8'h42, v); chk("R4 lane2 kept", v, 8'hFF);

    // R6 command during busy
    run_cmd(2'd0, 8'h48, 1, 8'h55, 1'b1);
    run_cmd(2'd0, 8'h50, 1, 8'h77, 1'b1);
    chk("R6 still busy", busy, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R6 no second window", busy, 0);
    rd(2'd0, 8'h50, v); chk("R6 ignored data", v, 8'hFF);
    rd(2'd0, 8'h48, v); chk("R6 first kept", v, 8'h55);

    // R7 protect low during loading
    @(negedge clk); cmd_open = 1'b1; bank = 2'd0; addr = 8'h60;
    @(negedge clk); cmd_open = 1'b0; byte_vld = 1'b1; byte_d = 8'h12; wp_hi = 1'b0;
    @(negedge clk); byte_vld = 1'b0; wp_hi = 1'b1;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R7 busy", busy, 0);
    rd(2'd0, 8'h60, v); chk("R7 data", v, 8'hFF);

    // R8 protect low in write window
    run_cmd(2'd0, 8'h70, 2, 8'h90, 1'b1);
    repeat (3) @(negedge clk);
    wp_hi = 1'b0;
    @(negedge clk);
    chk("R8 busy ends", busy, 0);
    wp_hi = 1'b1;
    rd(2'd0, 8'h70, v); chk("R8 marker lane0", v, 8'hA5);
    rd(2'd0, 8'h71, v); chk("R8 marker lane1", v, 8'hA5);
    rd(2'd0, 8'h72, v); chk("R8 lane2 kept", v, 8'hFF);

    // R9 low supply at STOP
    low_vdd = 1'b1;
    run_cmd(2'd0, 8'h78, 1, 8'h66, 1'b1);
    chk("R9 busy", busy, 0);
    low_vdd = 1'b0;
    rd(2'd0, 8'h78, v); chk("R9 data", v, 8'hFF);

    // R10 STOP without data
    run_cmd(2'd2, 8'h30, 0, 8'h00, 1'b1);
    chk("R10 busy", busy, 0);

    // R11 out-of-range bank ignored
    run_cmd(2'd3, 8'h20, 1, 8'h44, 1'b1);
    chk("R11 bad bank busy", busy, 0);
    rd(2'd0, 8'h20, v); chk("R11 bank0 kept", v, 8'hFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule